// File: doc/BRIEF.md
# Audio codec control register bank

This block holds the control and identification registers of a serial-link stereo audio codec. A host reaches it through a synchronous port that carries a 7-bit even register address, a write strobe and 16-bit data. The block drives the settings straight to the rest of the codec: the variable-rate enable, the playback (DAC) and capture (ADC) sample rates, and eight powerdown control bits. The ready-status bits it returns are formed from section-ready inputs, masked by those powerdown bits.

It also steers the serial return line. Several codecs can share one return wire to the controller. A codec whose chain-select field matches its own two identity pins drives its local frame data. A codec whose field differs passes the chained input from the next codec straight through.

A two-state control machine sequences start-up. Reset puts it in `ST_LOAD`. There every register takes its default value, the identity pins are sampled again, and host writes are refused. The transition `ST_LOAD -> ST_RUN` is taken unconditionally on the next clock. `ST_RUN` holds until the next reset, which is the transition `ST_RUN -> ST_LOAD`. Host writes are accepted only in `ST_RUN`.

Top module: `audio_ctl_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the following take their defaults: `var_rate_en` = 0, both rates = 16'hBB80 (48000), `pd_ctrl` = 0, `rd_data` = 0, and the chain-select field takes the value of `id_pins`.
- R2: In the first cycle after `rst` falls, any write is ignored and the chain-select field takes `id_pins` again. From the cycle after that on, writes take effect.
- R3: A write to address 7'h2A stores `wr_data[0]` as `var_rate_en`. A read of 7'h2A returns that bit in bit 0 and zeros in bits 15:1.
- R4: Writes to 7'h2C (DAC rate) and 7'h32 (ADC rate) are clamped into the range 4000..48000. Values below 4000 store 4000, values above 48000 store 48000, and values inside the range are stored unchanged.
- R5: Address 7'h26 reads as follows. Bits 15:8 are the writable powerdown field, output as `pd_ctrl`, with bit 8 = `pd_ctrl[0]`. Bits 7:4 read 0. Status bit i (for i = 0..3) reads `sect_ready[i]` AND NOT `pd_ctrl[i]`. Write data in bits 7:0 has no effect.
- R6: A write to 7'h74 stores `wr_data[1:0]` as the chain-select field, and a read returns it in bits 1:0. `chain_pass` = 1 exactly when that field differs from the current `id_pins`. `sdata_ret` equals `chain_in` when `chain_pass` = 1 and `local_sdata` otherwise.
- R7: Address 7'h7C reads 16'h4E53 and 7'h7E reads 16'h4350. Writes to them change nothing.
- R8: Every other address, odd ones included, reads 16'h0000. Writes to such an address change no register.
- R9: `rd_data` is registered. After a clock edge it shows the word at `reg_addr` as it was before any write taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_pins | input | 2 | Codec identity pins |
| sect_ready | input | 4 | Ready flags of the four analog sections |
| reg_addr | input | 7 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| var_rate_en | output | 1 | Variable-rate mode enable |
| dac_rate | output | 16 | Playback sample rate |
| adc_rate | output | 16 | Capture sample rate |
| pd_ctrl | output | 8 | Powerdown control bits |
| chain_pass | output | 1 | Chained input routed to the return line |
| local_sdata | input | 1 | Local serial frame data |
| chain_in | input | 1 | Serial data from the downstream codec |
| sdata_ret | output | 1 | Serial return output |

## Verification
The rate registers are written with values below, at, and above each limit, and one inside the range, so that an off-by-one in either clamp bound shows up. The powerdown field is written with several patterns while `sect_ready` changes, which tells an unmasked status bit or a wrong bit pairing apart from correct masking. The identity pins are changed both during the load cycle and later, with the return inputs toggling, so that a stale identity sample or an inverted match drives the wrong bit. Writes to the vendor, reserved and odd addresses are each followed by a read of every register, which exposes any side effect a partial decode would cause.

// File: rtl/acr_pkg.sv
package acr_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_PWR   = 7'h26;
    localparam logic [ADDR_W-1:0] A_EXT   = 7'h2A;
    localparam logic [ADDR_W-1:0] A_DACR  = 7'h2C;
    localparam logic [ADDR_W-1:0] A_ADCR  = 7'h32;
    localparam logic [ADDR_W-1:0] A_CHAIN = 7'h74;
    localparam logic [ADDR_W-1:0] A_VID0  = 7'h7C;
    localparam logic [ADDR_W-1:0] A_VID1  = 7'h7E;

    localparam logic [DATA_W-1:0] VID0_WORD = 16'h4E53;
    localparam logic [DATA_W-1:0] VID1_WORD = 16'h4350;

    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } acr_state_t;
endpackage

// File: rtl/acr_ctrl_fsm.sv
module acr_ctrl_fsm
    import acr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic run,
    output logic load
);
    acr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOAD;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_LOAD;
        endcase
    end

    always_comb begin
        run  = (state_q == ST_RUN);
        load = (state_q == ST_LOAD);
    end

    // R2: the load state lasts exactly one cycle
    assert_load_once_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> run);
endmodule

// File: rtl/acr_status.sv
module acr_status #(
    parameter int ID_W   = 2,
    parameter int PD_W   = 8,
    parameter int N_SECT = 4
) (
    input  logic [PD_W-1:0]   pd_ctrl,
    input  logic [N_SECT-1:0] sect_ready,
    input  logic [ID_W-1:0]   chain_sel,
    input  logic [ID_W-1:0]   id_pins,
    input  logic              local_sdata,
    input  logic              chain_in,
    output logic [N_SECT-1:0] status,
    output logic              chain_pass,
    output logic              sdata_ret
);
    genvar g;
    generate
        for (g = 0; g < N_SECT; g++) begin : g_sect
            assign status[g] = sect_ready[g] & ~pd_ctrl[g];
        end
    endgenerate

    always_comb begin
        chain_pass = (chain_sel != id_pins);
        sdata_ret  = chain_pass ? chain_in : local_sdata;
    end
endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
    import acr_pkg::*;
#(
    parameter int ID_W     = 2,
    parameter int PD_W     = 8,
    parameter int N_SECT   = 4,
    parameter int RATE_MIN = 4000,
    parameter int RATE_MAX = 48000,
    parameter int RATE_DEF = 48000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load,
    input  logic [ID_W-1:0]   id_pins,
    input  logic [N_SECT-1:0] status,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              var_rate_en,
    output logic [DATA_W-1:0] dac_rate,
    output logic [DATA_W-1:0] adc_rate,
    output logic [PD_W-1:0]   pd_ctrl,
    output logic [ID_W-1:0]   chain_sel
);
    localparam logic [DATA_W-1:0] RMIN = DATA_W'(RATE_MIN);
    localparam logic [DATA_W-1:0] RMAX = DATA_W'(RATE_MAX);
    localparam logic [DATA_W-1:0] RDEF = DATA_W'(RATE_DEF);

    logic              vra_q;
    logic [DATA_W-1:0] dac_q, adc_q, rd_q, rd_word;
    logic [PD_W-1:0]   pd_q;
    logic [ID_W-1:0]   sel_q;
    logic              wr_ok, writable;

    function automatic logic [DATA_W-1:0] clamp_rate(input logic [DATA_W-1:0] v);
        if (v < RMIN)      return RMIN;
        else if (v > RMAX) return RMAX;
        else               return v;
    endfunction

    always_comb begin
        wr_ok    = run & wr_en;
        writable = (reg_addr == A_EXT) || (reg_addr == A_DACR) || (reg_addr == A_ADCR)
                || (reg_addr == A_PWR) || (reg_addr == A_CHAIN);
    end

    always_comb begin
        rd_word = '0;
        case (reg_addr)
            A_EXT:   rd_word[0] = vra_q;
            A_DACR:  rd_word = dac_q;
            A_ADCR:  rd_word = adc_q;
            A_PWR: begin
                rd_word[DATA_W-1 -: PD_W] = pd_q;
                rd_word[N_SECT-1:0]       = status;
            end
            A_CHAIN: rd_word[ID_W-1:0] = sel_q;
            A_VID0:  rd_word = VID0_WORD;
            A_VID1:  rd_word = VID1_WORD;
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vra_q <= 1'b0;
            dac_q <= RDEF;
            adc_q <= RDEF;
            pd_q  <= '0;
            sel_q <= id_pins;
            rd_q  <= '0;
        end else begin
            rd_q <= rd_word;
            if (load) sel_q <= id_pins;
            if (wr_ok) begin
                case (reg_addr)
                    A_EXT:   vra_q <= wr_data[0];
                    A_DACR:  dac_q <= clamp_rate(wr_data);
                    A_ADCR:  adc_q <= clamp_rate(wr_data);
                    A_PWR:   pd_q  <= wr_data[DATA_W-1 -: PD_W];
                    A_CHAIN: sel_q <= wr_data[ID_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data     = rd_q;
        var_rate_en = vra_q;
        dac_rate    = dac_q;
        adc_rate    = adc_q;
        pd_ctrl     = pd_q;
        chain_sel   = sel_q;
    end

    // R1: reset restores the defaults
    assert_reset_defaults_R1: assert property (@(posedge clk)
        rst |=> (dac_q == RDEF && adc_q == RDEF && !vra_q && pd_q == '0 && rd_q == '0));

    // R3: an accepted write to the extended control register lands
    assert_vra_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && reg_addr == A_EXT) |=> (vra_q == $past(wr_data[0])));

    // R4: both rates stay inside the legal range
    assert_rate_range_R4: assert property (@(posedge clk) disable iff (rst)
        (dac_q >= RMIN && dac_q <= RMAX && adc_q >= RMIN && adc_q <= RMAX));

    // R8: writes to unimplemented or read-only addresses touch nothing
    assert_no_side_write_R8: assert property (@(posedge clk) disable iff (rst)
        (run && wr_en && !writable) |=> ($stable(vra_q) && $stable(dac_q) && $stable(adc_q)
                                         && $stable(pd_q) && $stable(sel_q)));
endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
    import acr_pkg::*;
#(
    parameter int ID_W     = 2,
    parameter int PD_W     = 8,
    parameter int N_SECT   = 4,
    parameter int RATE_MIN = 4000,
    parameter int RATE_MAX = 48000,
    parameter int RATE_DEF = 48000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   id_pins,
    input  logic [N_SECT-1:0] sect_ready,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              var_rate_en,
    output logic [DATA_W-1:0] dac_rate,
    output logic [DATA_W-1:0] adc_rate,
    output logic [PD_W-1:0]   pd_ctrl,
    output logic              chain_pass,
    input  logic              local_sdata,
    input  logic              chain_in,
    output logic              sdata_ret
);
    logic              run, load;
    logic [N_SECT-1:0] status;
    logic [ID_W-1:0]   chain_sel;

    acr_ctrl_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .load (load)
    );

    acr_regfile #(
        .ID_W(ID_W), .PD_W(PD_W), .N_SECT(N_SECT),
        .RATE_MIN(RATE_MIN), .RATE_MAX(RATE_MAX), .RATE_DEF(RATE_DEF)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .load        (load),
        .id_pins     (id_pins),
        .status      (status),
        .reg_addr    (reg_addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .var_rate_en (var_rate_en),
        .dac_rate    (dac_rate),
        .adc_rate    (adc_rate),
        .pd_ctrl     (pd_ctrl),
        .chain_sel   (chain_sel)
    );

    acr_status #(.ID_W(ID_W), .PD_W(PD_W), .N_SECT(N_SECT)) u_status (
        .pd_ctrl     (pd_ctrl),
        .sect_ready  (sect_ready),
        .chain_sel   (chain_sel),
        .id_pins     (id_pins),
        .local_sdata (local_sdata),
        .chain_in    (chain_in),
        .status      (status),
        .chain_pass  (chain_pass),
        .sdata_ret   (sdata_ret)
    );
endmodule

// File: tb/test_audio_ctl_regs.sv
module test_audio_ctl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  id_pins = 2'b10;
    logic [3:0]  sect_ready = 4'hF;
    logic [6:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, dac_rate, adc_rate;
    logic        var_rate_en, chain_pass, sdata_ret;
    logic [7:0]  pd_ctrl;
    logic        local_sdata = 1'b0;
    logic        chain_in = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    string phase = "R1";
    string rd_tag = "R1";

    int m_vra, m_dac, m_adc, m_pd, m_sel, m_load, m_rd;

    audio_ctl_regs i_audio_ctl_regs (
        .clk(clk), .rst(rst), .id_pins(id_pins), .sect_ready(sect_ready),
        .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .var_rate_en(var_rate_en), .dac_rate(dac_rate), .adc_rate(adc_rate),
        .pd_ctrl(pd_ctrl), .chain_pass(chain_pass), .local_sdata(local_sdata),
        .chain_in(chain_in), .sdata_ret(sdata_ret)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int clampv(int v);
        if (v < 4000) return 4000;
        if (v > 48000) return 48000;
        return v;
    endfunction

    function automatic int mstatus();
        int s = 0;
        for (int i = 0; i < 4; i++)
            if (sect_ready[i] && !m_pd[i]) s |= (1 << i);
        return s;
    endfunction

    function automatic int mread(int a);
        case (a)
            'h2A: return m_vra;
            'h2C: return m_dac;
            'h32: return m_adc;
            'h26: return (m_pd << 8) | mstatus();
            'h74: return m_sel;
            'h7C: return 'h4E53;
            'h7E: return 'h4350;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            'h7C, 'h7E: return "R7";
            'h26: return "R5";
            'h2A: return "R3";
            'h2C, 'h32: return "R4";
            'h74: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, string nm, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s actual=%h expected=%h at %0t", tag, phase, nm, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int rdv;
        rdv = mread(reg_addr);
        if (rst) begin
            m_vra = 0; m_dac = 48000; m_adc = 48000; m_pd = 0;
            m_sel = id_pins; m_load = 1; m_rd = 0; rd_tag = "R1";
        end else begin
            m_rd = rdv;
            rd_tag = (tag_of(reg_addr) == "R8") ? "R8" : "R9";
            if (m_load != 0) begin
                m_sel = id_pins;
                m_load = 0;
            end else if (wr_en) begin
                case (reg_addr)
                    'h2A: m_vra = wr_data[0];
                    'h2C: m_dac = clampv(wr_data);
                    'h32: m_adc = clampv(wr_data);
                    'h26: m_pd = wr_data[15:8];
                    'h74: m_sel = wr_data[1:0];
                    default: ;
                endcase
            end
        end
        #(CLK_PERIOD/4);
        chk("R3", "var_rate_en", var_rate_en, m_vra);
        chk("R4", "dac_rate", dac_rate, m_dac);
        chk("R4", "adc_rate", adc_rate, m_adc);
        chk("R5", "pd_ctrl", pd_ctrl, m_pd);
        chk("R6", "chain_pass", chain_pass, (m_sel != id_pins));
        chk("R6", "sdata_ret", sdata_ret, (m_sel != id_pins) ? chain_in : local_sdata);
        chk(rd_tag, "rd_data", rd_data, m_rd);
    end

    task automatic cyc(int a, bit we, int d);
        @(negedge clk);
        reg_addr = a[6:0];
        wr_en = we;
        wr_data = d[15:0];
    endtask

    task automatic read_all();
        int addrs[7] = '{'h26, 'h2A, 'h2C, 'h32, 'h74, 'h7C, 'h7E};
        foreach (addrs[k]) cyc(addrs[k], 1'b0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        phase = "R1 reset";
        repeat (3) @(negedge clk);
        // R2: leave reset with a write pending and new identity pins
        phase = "R2 load";
        rst = 1'b0; id_pins = 2'b01;
        reg_addr = 7'h2C; wr_en = 1'b1; wr_data = 16'h1F40;
        cyc('h74, 1'b0, 0);
        cyc('h74, 1'b0, 0);
        phase = "R3 ext";
        cyc('h2A, 1'b1, 'hFFFF);
        cyc('h2A, 1'b0, 0);
        cyc('h2A, 1'b1, 'h0002);
        cyc('h2A, 1'b1, 'h0001);
        phase = "R4 rates";
        begin
            int vals[9] = '{8000, 100, 'hFFFF, 4000, 3999, 48000, 48001, 4001, 22050};
            foreach (vals[k]) begin
                cyc('h2C, 1'b1, vals[k]);
                cyc('h32, 1'b1, vals[(k + 3) % 9]);
                cyc('h2C, 1'b0, 0);
            end
        end
        phase = "R5 powerdown";
        begin
            int pats[4] = '{'hA5FF, 'h0F0F, 'hF000, 'h5A00};
            foreach (pats[k]) begin
                cyc('h26, 1'b1, pats[k]);
                sect_ready = 4'(k * 5 + 3);
                cyc('h26, 1'b0, 0);
                sect_ready = 4'hF;
                cyc('h26, 1'b0, 0);
            end
        end
        phase = "R6 chain";
        for (int s = 0; s < 4; s++) begin
            cyc('h74, 1'b1, 'hFFF0 | s);
            for (int b = 0; b < 4; b++) begin
                chain_in = b[0]; local_sdata = b[1];
                cyc('h74, 1'b0, 0);
            end
            id_pins = 2'(s + 1);
            cyc('h74, 1'b0, 0);
        end
        phase = "R7 vendor";
        cyc('h7C, 1'b1, 'h1234);
        read_all();
        cyc('h7E, 1'b1, 'h0000);
        read_all();
        phase = "R8 reserved";
        cyc('h24, 1'b1, 'hFFFF);
        cyc('h5A, 1'b1, 'hFFFF);
        cyc('h2D, 1'b1, 'h0000);
        cyc('h27, 1'b1, 'h0000);
        cyc('h75, 1'b1, 'h0003);
        read_all();
        cyc('h2B, 1'b0, 0);
        phase = "R9 random";
        for (int n = 0; n < 600; n++) begin
            int a;
            a = (n % 3 == 0) ? int'($urandom_range(0, 127)) : 'h26 + 2 * int'($urandom_range(0, 44));
            chain_in = 1'($urandom); local_sdata = 1'($urandom);
            sect_ready = 4'($urandom);
            if (n % 50 == 0) id_pins = 2'($urandom);
            cyc(a, 1'($urandom), int'($urandom_range(0, 65535)));
        end
        phase = "R1 re-reset";
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        read_all();
        @(negedge clk);
        summary();
    end
endmodule